// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the register front end of an I2C master controller. Software reaches it through a byte-wide register port with seventeen offsets. A write to the control register can start a transfer of one to four bytes or halt an open transaction. Each byte is handed to a byte-level I2C engine over a request/acknowledge handshake. The handshake carries the 7-bit device address, the direction, one data byte and a flag that marks the first byte of a new transaction. The engine answers with an acknowledge, a NACK flag and, for reads, a received byte.

A four-entry data buffer sits at offset 0. Software pushes bytes there before a write transfer, and it pops received bytes from there after a read transfer. Status, extended status, the completed byte count and a level interrupt follow the progress of each transfer. The interrupt is gated by a global enable in the mode register and by a mask bit for each cause. A write to the extended-control register performs a soft reset, and the device address registers keep their values through it. The slave-address, clock-divider and line-control registers are only stored.

Offsets: 0 data buffer, 4 master address low, 5 master address high, 6 control, 7 mode, 8 status, 9 extended status, 10 slave address low, 11 slave address high, 12 clock divider, 13 interrupt mask, 14 byte count, 15 extended control, 16 line control. All other offsets read 0.

Top module: `i2c_master_regs`

## Requirements
- R1: After reset, the control, mode, status, byte-count, interrupt-mask and clock-divider registers read 0x00. Extended status reads 0x40, line control reads 0x0F, `irq` is low, and the data buffer reads 0xFF when it is empty.
- R2: Control bit 0 (go) starts a transfer and always reads back as 0. All other control bits read back as written.
- R3: A write to control with go set moves (bits 5:4)+1 bytes to the 7-bit address (master address low >> 1). Only the first request of a transaction, made while the bus is idle, carries `eng_start`. Write data comes from the buffer in push order. The byte count register then holds the number of bytes completed, and the buffer is emptied after a write.
- R4: A read transfer (control bit 1 set) fills the buffer in arrival order. Status bit 5 is set while the buffer holds data and status bit 4 is set when it holds 4 bytes. Reads at offset 0 pop bytes in order and return 0xFF when the buffer is empty.
- R5: A NACK stops the transfer at that byte. It sets status bit 2 and extended-status bit 0, and the byte count holds only the bytes completed before it. Status bit 2 is cleared only when a later transfer starts on an idle bus.
- R6: At the end of a transfer the transaction is closed (a pulse on `eng_stop`) if an error occurred, if control bit 3 (repeated start) is set, or if control bit 2 (chain) is clear. Otherwise the bus stays busy. Extended-status bits 6:4 read 5 while the bus is busy and 4 while it is free.
- R7: A control write with bit 7 (halt) set while the bus is busy closes the transaction. If mode bit 2 and mask bit 3 are both set, it also sets status bit 1 and raises `irq`.
- R8: A transfer that completes at least one byte sets status bit 1 and raises `irq` only when mode bit 2 and mask bit 0 are both set.
- R9: A write to status clears only bit 1 (and bit 3) where ones are written. Clearing bit 1 while mode bit 2 is set lowers `irq`. Bit 2 is not affected by status writes.
- R10: Writes are stored through masks: mode keeps 0x3D, byte count keeps 0x77, and line control keeps bits 3:0. A write to extended status clears the written bits within 0x8F.
- R11: A mode write with bit 6 set empties the data buffer, and bit 6 is not stored.
- R12: The buffer holds at most 4 bytes. A push into a full buffer is ignored.
- R13: A write to extended control with bit 0 set is a soft reset. It returns every register to its R1 value except the four address registers, and it closes an open transaction.
- R14: A write to master address low while the bus is busy closes the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the buffer at offset 0) |
| reg_addr | input | 5 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Level interrupt |
| eng_req | output | 1 | Byte request, held until acknowledged |
| eng_start | output | 1 | Request opens a new transaction |
| eng_rd | output | 1 | Request is a read |
| eng_addr | output | 7 | 7-bit device address |
| eng_wdata | output | 8 | Byte to send |
| eng_ack | input | 1 | Engine finished the requested byte |
| eng_nack | input | 1 | Byte failed (valid with ack) |
| eng_rdata | input | 8 | Received byte (valid with ack) |
| eng_stop | output | 1 | One-cycle pulse that closes the transaction |

## Verification
The bench goes after the boundaries of the byte count. A 4-byte read must fill the buffer and raise the full flag, and a design that got the count field wrong would move one byte too few or too many. A NACK on the second byte must leave a count of 1 with the error flags set. A design that kept going after the NACK, or that counted the failing byte, would report 2 or 3 instead.

A chained transfer must keep the bus busy, and the transfer after it must not carry a start flag. A halt, a master-address write and a soft reset must each produce exactly one stop. Interrupts are tried with only one of the enable and mask bits set, where a design that ignored a gate would raise `irq`. The mask, write-one-to-clear and overfill cases each catch a design that stored or cleared the wrong bits.

// File: rtl/i2c_master_regs_pkg.sv
package i2c_master_regs_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 5;
  localparam int BUF_DEPTH = 4;
  localparam int IDX_W     = $clog2(BUF_DEPTH);
  localparam int CNT_W     = IDX_W + 1;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_DATA     = 5'd0;
  localparam logic [ADDR_W-1:0] OFS_MADDR_LO = 5'd4;
  localparam logic [ADDR_W-1:0] OFS_MADDR_HI = 5'd5;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 5'd6;
  localparam logic [ADDR_W-1:0] OFS_MODE     = 5'd7;
  localparam logic [ADDR_W-1:0] OFS_STAT     = 5'd8;
  localparam logic [ADDR_W-1:0] OFS_XSTAT    = 5'd9;
  localparam logic [ADDR_W-1:0] OFS_SADDR_LO = 5'd10;
  localparam logic [ADDR_W-1:0] OFS_SADDR_HI = 5'd11;
  localparam logic [ADDR_W-1:0] OFS_CLKDIV   = 5'd12;
  localparam logic [ADDR_W-1:0] OFS_IMASK    = 5'd13;
  localparam logic [ADDR_W-1:0] OFS_BYTECNT  = 5'd14;
  localparam logic [ADDR_W-1:0] OFS_XCTRL    = 5'd15;
  localparam logic [ADDR_W-1:0] OFS_LINES    = 5'd16;

  // control bits
  localparam int CT_GO     = 0;
  localparam int CT_RD     = 1;
  localparam int CT_CHAIN  = 2;
  localparam int CT_RSTART = 3;
  localparam int CT_HALT   = 7;
  // mode bits
  localparam int MD_IEN    = 2;
  localparam int MD_FLUSH  = 6;
  // status bits
  localparam int ST_IRQ    = 1;
  localparam int ST_SPARE  = 3;
  // interrupt mask bits
  localparam int IM_DONE   = 0;
  localparam int IM_HALT   = 3;
  // extended control
  localparam int XC_SRST   = 0;

  localparam logic [DATA_W-1:0] MODE_KEEP = 8'h3D;
  localparam logic [DATA_W-1:0] CNT_KEEP  = 8'h77;
  localparam logic [DATA_W-1:0] XST_CLR   = 8'h8F;
  localparam logic [DATA_W-1:0] LINES_RST = 8'h0F;
  localparam logic [2:0]        BCS_FREE  = 3'd4;
  localparam logic [2:0]        BCS_BUSY  = 3'd5;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_FIN} seq_state_e;

  // number of bytes requested by a control value
  function automatic logic [CNT_W-1:0] xfer_len(input logic [DATA_W-1:0] ctrl);
    return CNT_W'(ctrl[5:4]) + CNT_W'(1);
  endfunction

  // extended status as seen by software
  function automatic logic [DATA_W-1:0] xstat_view(input logic busy,
                                                   input logic [DATA_W-1:0] st);
    return {st[7], (busy ? BCS_BUSY : BCS_FREE), st[3:0]};
  endfunction

  // status register as seen by software
  function automatic logic [DATA_W-1:0] stat_view(input logic active, input logic irq_st,
                                                  input logic err, input logic full,
                                                  input logic nempty);
    return {2'b00, nempty, full, 1'b0, err, irq_st, active};
  endfunction
endpackage

// File: rtl/i2c_mreg_fifo.sv
module i2c_mreg_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  input  logic             set_lvl,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic             wr_at,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_data,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full
);
  logic [W-1:0]     mem [DEPTH];
  logic [LVL_W-1:0] level;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign head    = mem[0];
  assign rd_data = mem[rd_idx];

  logic do_pop, do_push;
  assign do_pop  = pop && !empty;
  assign do_push = push && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            level <= '0;
    else if (flush)        level <= '0;
    else if (set_lvl)      level <= lvl_in;
    else if (do_pop)       level <= level - LVL_W'(1);
    else if (do_push)      level <= level + LVL_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [W-1:0] shift_in;
    if (g == DEPTH - 1) begin : g_last
      assign shift_in = '0;
    end else begin : g_mid
      assign shift_in = mem[g+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     mem[g] <= '0;
      else if (flush)                                 mem[g] <= '0;
      else if (wr_at && wr_idx == IDX_W'(g))          mem[g] <= wr_data;
      else if (do_pop)                                mem[g] <= shift_in;
      else if (do_push && level == LVL_W'(g))         mem[g] <= push_data;
    end
  end
endmodule

// File: rtl/i2c_mreg_seq.sv
module i2c_mreg_seq
  import i2c_master_regs_pkg::*;
#(
  parameter int LEN_W = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             go,
  input  logic             go_rd,
  input  logic [LEN_W-1:0] go_len,
  input  logic             eng_ack,
  input  logic             eng_nack,
  output logic             eng_req,
  output logic             xfer_rd,
  output logic             active,
  output logic [LEN_W-1:0] byte_idx,
  output logic             rx_wr,
  output logic             done,
  output logic [LEN_W-1:0] done_cnt,
  output logic             done_err
);
  seq_state_e       state;
  logic [LEN_W-1:0] idx, len;
  logic             rd_q, err_q;
  logic             byte_ok, last_byte;

  assign byte_ok   = (state == SQ_REQ) && eng_ack && !eng_nack;
  assign last_byte = (idx + LEN_W'(1)) == len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      idx   <= '0;
      len   <= '0;
      rd_q  <= 1'b0;
      err_q <= 1'b0;
    end else if (abort) begin
      state <= SQ_IDLE;
      idx   <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: if (go) begin
          state <= SQ_REQ;
          idx   <= '0;
          len   <= go_len;
          rd_q  <= go_rd;
          err_q <= 1'b0;
        end
        SQ_REQ: if (eng_ack) begin
          if (eng_nack) begin
            err_q <= 1'b1;
            state <= SQ_FIN;
          end else begin
            idx <= idx + LEN_W'(1);
            if (last_byte) state <= SQ_FIN;
          end
        end
        SQ_FIN: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign eng_req  = (state == SQ_REQ);
  assign xfer_rd  = rd_q;
  assign active   = (state != SQ_IDLE);
  assign byte_idx = idx;
  assign rx_wr    = byte_ok && rd_q;
  assign done     = (state == SQ_FIN);
  assign done_cnt = idx;
  assign done_err = err_q;
endmodule

// File: rtl/i2c_master_regs.sv
module i2c_master_regs
  import i2c_master_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              eng_req,
  output logic              eng_start,
  output logic              eng_rd,
  output logic [6:0]        eng_addr,
  output logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_ack,
  input  logic              eng_nack,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              eng_stop
);
  localparam int LVL_W = $clog2(BUF_DEPTH + 1);

  // stored registers
  logic [DATA_W-1:0] maddr_lo, maddr_hi, saddr_lo, saddr_hi;
  logic [DATA_W-1:0] ctrl_q, mode_q, xst_q, clkdiv_q, imask_q, bcnt_q, xctrl_q, lines_q;
  logic              irq_st, err_st, bus_busy, stop_q, irq_q;

  // sequencer and buffer wires
  logic             seq_active, seq_done, seq_err, seq_rd, rx_wr;
  logic [CNT_W-1:0] byte_idx, done_cnt;
  logic [DATA_W-1:0] buf_head, buf_tx;
  logic             buf_empty, buf_full;

  // named events
  logic wr_data_e, wr_ctrl_e, wr_mode_e, wr_stat_e, wr_xst_e, wr_maddr_lo_e;
  logic soft_rst, ctrl_wr_ok, halt_evt, go_evt, start_ok;
  logic fin_stop, maddr_stop, stop_evt, irq_done_evt, irq_halt_evt, irq_set, irq_clr;
  logic buf_flush, buf_pop;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] ofs);
    return a == ofs;
  endfunction

  assign wr_data_e     = reg_wr && hit(reg_addr, OFS_DATA);
  assign wr_ctrl_e     = reg_wr && hit(reg_addr, OFS_CTRL);
  assign wr_mode_e     = reg_wr && hit(reg_addr, OFS_MODE);
  assign wr_stat_e     = reg_wr && hit(reg_addr, OFS_STAT);
  assign wr_xst_e      = reg_wr && hit(reg_addr, OFS_XSTAT);
  assign wr_maddr_lo_e = reg_wr && hit(reg_addr, OFS_MADDR_LO);
  assign soft_rst      = reg_wr && hit(reg_addr, OFS_XCTRL) && reg_wdata[XC_SRST];

  assign ctrl_wr_ok   = wr_ctrl_e && !seq_active;
  assign halt_evt     = ctrl_wr_ok && reg_wdata[CT_HALT] && bus_busy;
  assign go_evt       = ctrl_wr_ok && reg_wdata[CT_GO] && !halt_evt;
  assign start_ok     = eng_req && eng_ack && !eng_nack && eng_start;
  assign fin_stop     = seq_done && bus_busy &&
                        (seq_err || ctrl_q[CT_RSTART] || !ctrl_q[CT_CHAIN]);
  assign maddr_stop   = wr_maddr_lo_e && bus_busy;
  assign stop_evt     = halt_evt || fin_stop || maddr_stop || (soft_rst && bus_busy);
  assign irq_done_evt = seq_done && (done_cnt != '0) && mode_q[MD_IEN] && imask_q[IM_DONE];
  assign irq_halt_evt = halt_evt && mode_q[MD_IEN] && imask_q[IM_HALT];
  assign irq_set      = irq_done_evt || irq_halt_evt;
  assign irq_clr      = wr_stat_e && reg_wdata[ST_IRQ];
  assign buf_flush    = soft_rst || (wr_mode_e && reg_wdata[MD_FLUSH]);
  assign buf_pop      = reg_rd && hit(reg_addr, OFS_DATA);

  i2c_mreg_seq #(.LEN_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (soft_rst),
    .go       (go_evt),
    .go_rd    (reg_wdata[CT_RD]),
    .go_len   (xfer_len(reg_wdata)),
    .eng_ack  (eng_ack),
    .eng_nack (eng_nack),
    .eng_req  (eng_req),
    .xfer_rd  (seq_rd),
    .active   (seq_active),
    .byte_idx (byte_idx),
    .rx_wr    (rx_wr),
    .done     (seq_done),
    .done_cnt (done_cnt),
    .done_err (seq_err)
  );

  i2c_mreg_fifo #(.DEPTH(BUF_DEPTH), .W(DATA_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (buf_flush),
    .push      (wr_data_e),
    .push_data (reg_wdata),
    .pop       (buf_pop),
    .set_lvl   (seq_done),
    .lvl_in    (seq_rd ? LVL_W'(done_cnt) : LVL_W'(0)),
    .wr_at     (rx_wr),
    .wr_idx    (byte_idx[IDX_W-1:0]),
    .wr_data   (eng_rdata),
    .rd_idx    (byte_idx[IDX_W-1:0]),
    .rd_data   (buf_tx),
    .head      (buf_head),
    .empty     (buf_empty),
    .full      (buf_full)
  );

  // addresses: cleared only by the reset pin
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr_lo <= '0;
      maddr_hi <= '0;
      saddr_lo <= '0;
      saddr_hi <= '0;
    end else if (reg_wr) begin
      if (hit(reg_addr, OFS_MADDR_LO)) maddr_lo <= reg_wdata;
      if (hit(reg_addr, OFS_MADDR_HI)) maddr_hi <= reg_wdata;
      if (hit(reg_addr, OFS_SADDR_LO)) saddr_lo <= reg_wdata;
      if (hit(reg_addr, OFS_SADDR_HI)) saddr_hi <= reg_wdata;
    end
  end

  // control, mode and plain stored registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      clkdiv_q <= '0;
      imask_q  <= '0;
      xctrl_q  <= '0;
      lines_q  <= LINES_RST;
    end else if (soft_rst) begin
      ctrl_q   <= '0;
      mode_q   <= '0;
      clkdiv_q <= '0;
      imask_q  <= '0;
      xctrl_q  <= '0;
      lines_q  <= LINES_RST;
    end else begin
      if (ctrl_wr_ok) ctrl_q <= reg_wdata & ~(DATA_W'(1) << CT_GO);
      if (wr_mode_e)  mode_q <= reg_wdata & MODE_KEEP;
      if (reg_wr && hit(reg_addr, OFS_CLKDIV)) clkdiv_q <= reg_wdata;
      if (reg_wr && hit(reg_addr, OFS_IMASK))  imask_q  <= reg_wdata;
      if (reg_wr && hit(reg_addr, OFS_XCTRL))  xctrl_q  <= reg_wdata;
      if (reg_wr && hit(reg_addr, OFS_LINES))  lines_q  <= reg_wdata & LINES_RST;
    end
  end

  // byte count and error tracking
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q <= '0;
      err_st <= 1'b0;
      xst_q  <= '0;
    end else if (soft_rst) begin
      bcnt_q <= '0;
      err_st <= 1'b0;
      xst_q  <= '0;
    end else begin
      if (seq_done)
        bcnt_q <= DATA_W'(done_cnt);
      else if (reg_wr && hit(reg_addr, OFS_BYTECNT))
        bcnt_q <= reg_wdata & CNT_KEEP;

      if (seq_done && seq_err)     err_st <= 1'b1;
      else if (go_evt && !bus_busy) err_st <= 1'b0;

      if (seq_done && seq_err)  xst_q <= xst_q | 8'h01;
      else if (wr_xst_e)        xst_q <= xst_q & ~(reg_wdata & XST_CLR);
    end
  end

  // interrupt status and line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_st <= 1'b0;
      irq_q  <= 1'b0;
    end else if (soft_rst) begin
      irq_st <= 1'b0;
      irq_q  <= 1'b0;
    end else if (irq_set) begin
      irq_st <= 1'b1;
      irq_q  <= 1'b1;
    end else if (irq_clr) begin
      irq_st <= 1'b0;
      if (mode_q[MD_IEN]) irq_q <= 1'b0;
    end
  end

  // transaction state and stop pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      stop_q <= stop_evt;
      if (stop_evt || soft_rst) bus_busy <= 1'b0;
      else if (start_ok)        bus_busy <= 1'b1;
    end
  end

  assign irq       = irq_q;
  assign eng_stop  = stop_q;
  assign eng_start = !bus_busy;
  assign eng_rd    = seq_rd;
  assign eng_addr  = maddr_lo[7:1];
  assign eng_wdata = buf_tx;

  // read mux
  always_comb begin
    unique case (reg_addr)
      OFS_DATA:     reg_rdata = buf_empty ? 8'hFF : buf_head;
      OFS_MADDR_LO: reg_rdata = maddr_lo;
      OFS_MADDR_HI: reg_rdata = maddr_hi;
      OFS_CTRL:     reg_rdata = ctrl_q;
      OFS_MODE:     reg_rdata = mode_q;
      OFS_STAT:     reg_rdata = stat_view(seq_active, irq_st, err_st, buf_full, !buf_empty);
      OFS_XSTAT:    reg_rdata = xstat_view(bus_busy, xst_q);
      OFS_SADDR_LO: reg_rdata = saddr_lo;
      OFS_SADDR_HI: reg_rdata = saddr_hi;
      OFS_CLKDIV:   reg_rdata = clkdiv_q;
      OFS_IMASK:    reg_rdata = imask_q;
      OFS_BYTECNT:  reg_rdata = bcnt_q;
      OFS_XCTRL:    reg_rdata = xctrl_q;
      OFS_LINES:    reg_rdata = lines_q;
      default:      reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_master_regs_chk.sv
module i2c_master_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd,
  input logic [4:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic       irq,
  input logic       eng_req,
  input logic       eng_ack,
  input logic       eng_stop,
  input logic       bus_busy,
  input logic       mode_ien,
  input logic       soft_rst,
  input logic       buf_empty
);
  AST_GO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 5'd6) |-> !reg_rdata[0]); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_ack && !soft_rst) |=> eng_req); // R3

  AST_BUSY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(eng_ack)); // R3

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 5'd0 && buf_empty) |-> reg_rdata == 8'hFF); // R4

  AST_STOP_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop |-> ($past(bus_busy) && !bus_busy)); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mode_ien)); // R8
endmodule

bind i2c_master_regs i2c_master_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .eng_req   (eng_req),
  .eng_ack   (eng_ack),
  .eng_stop  (eng_stop),
  .bus_busy  (bus_busy),
  .mode_ien  (mode_q[2]),
  .soft_rst  (soft_rst),
  .buf_empty (buf_empty)
);

// File: tb/tb_i2c_master_regs.sv
`timescale 1ns/1ps
module tb_i2c_master_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq, eng_req, eng_start, eng_rd, eng_stop;
  logic [6:0] eng_addr;
  logic [7:0] eng_wdata;
  logic       eng_ack = 1'b0, eng_nack = 1'b0;
  logic [7:0] eng_rdata = '0;

  always #2 clk = ~clk;

  i2c_master_regs dut (.*);

  int checks = 0, errors = 0;
  int req_cnt = 0, nack_at = -1, stop_cnt = 0;
  logic [7:0] log_wd [8];
  logic [6:0] log_ad [8];
  logic       log_st [8];
  logic       log_rd [8];
  logic       finished = 1'b0;

  // byte engine model
  initial begin
    forever begin
      @(negedge clk);
      if (eng_stop) stop_cnt++;
      if (eng_req && !eng_ack) begin
        if (req_cnt < 8) begin
          log_wd[req_cnt] = eng_wdata;
          log_ad[req_cnt] = eng_addr;
          log_st[req_cnt] = eng_start;
          log_rd[req_cnt] = eng_rd;
        end
        eng_nack  = (req_cnt == nack_at);
        eng_rdata = 8'hA0 + 8'(req_cnt);
        eng_ack   = 1'b1;
        req_cnt++;
      end else begin
        eng_ack  = 1'b0;
        eng_nack = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 60; i++) begin
      rd(5'd8, s);
      if (!s[0]) break;
    end
  endtask

  task automatic clear_engine();
    req_cnt = 0;
    nack_at = -1;
  endtask

  task automatic t_reset(); // R1
    rd_chk("R1 ctrl", 5'd6, 8'h00);
    rd_chk("R1 mode", 5'd7, 8'h00);
    rd_chk("R1 stat", 5'd8, 8'h00);
    rd_chk("R1 xstat", 5'd9, 8'h40);
    rd_chk("R1 lines", 5'd16, 8'h0F);
    rd_chk("R1 bytecnt", 5'd14, 8'h00);
    rd_chk("R1 empty data", 5'd0, 8'hFF);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_ctrl_readback(); // R2
    wr(5'd6, 8'h4E);
    rd_chk("R2 ctrl stored", 5'd6, 8'h4E);
    wr(5'd6, 8'h00);
  endtask

  task automatic t_write_xfer(); // R3
    int s0;
    clear_engine();
    s0 = stop_cnt;
    wr(5'd0, 8'h11); wr(5'd0, 8'h22); wr(5'd0, 8'h33);
    wr(5'd4, 8'h52);
    wr(5'd6, 8'h21);
    wait_idle();
    chk("R3 request count", 8'(req_cnt), 8'd3);
    chk("R3 addr", {1'b0, log_ad[0]}, 8'h29);
    chk("R3 start first", {7'b0, log_st[0]}, 8'h01);
    chk("R3 start second", {7'b0, log_st[1]}, 8'h00);
    chk("R3 dir", {7'b0, log_rd[2]}, 8'h00);
    chk("R3 byte0", log_wd[0], 8'h11);
    chk("R3 byte2", log_wd[2], 8'h33);
    rd_chk("R3 bytecnt", 5'd14, 8'h03);
    rd_chk("R3 go reads 0", 5'd6, 8'h20);
    rd_chk("R3 buffer emptied", 5'd8, 8'h00);
    chk("R6 stop after unchained", 8'(stop_cnt - s0), 8'd1);
    rd_chk("R6 bus free", 5'd9, 8'h40);
  endtask

  task automatic t_read_xfer(); // R4
    clear_engine();
    wr(5'd4, 8'hA1);
    wr(5'd6, 8'h33);
    wait_idle();
    chk("R4 read addr", {1'b0, log_ad[0]}, 8'h50);
    chk("R4 read dir", {7'b0, log_rd[0]}, 8'h01);
    rd_chk("R4 full+nonempty", 5'd8, 8'h30);
    rd_chk("R4 bytecnt", 5'd14, 8'h04);
    rd_chk("R4 pop0", 5'd0, 8'hA0);
    rd_chk("R4 after pop", 5'd8, 8'h20);
    rd_chk("R4 pop1", 5'd0, 8'hA1);
    rd_chk("R4 pop2", 5'd0, 8'hA2);
    rd_chk("R4 pop3", 5'd0, 8'hA3);
    rd_chk("R4 empty", 5'd0, 8'hFF);
  endtask

  task automatic t_nack(); // R5, R9, R10
    int s0;
    clear_engine();
    nack_at = 1;
    s0 = stop_cnt;
    wr(5'd0, 8'h01); wr(5'd0, 8'h02); wr(5'd0, 8'h03);
    wr(5'd6, 8'h21);
    wait_idle();
    chk("R5 stopped at nack", 8'(req_cnt), 8'd2);
    rd_chk("R5 bytecnt", 5'd14, 8'h01);
    rd_chk("R5 err", 5'd8, 8'h04);
    rd_chk("R5 xstat err", 5'd9, 8'h41);
    chk("R5 stop", 8'(stop_cnt - s0), 8'd1);
    wr(5'd8, 8'hFF);
    rd_chk("R9 err kept", 5'd8, 8'h04);
    wr(5'd9, 8'h01);
    rd_chk("R10 xstat w1c", 5'd9, 8'h40);
  endtask

  task automatic t_irq(); // R8, R9, R5
    clear_engine();
    wr(5'd7, 8'h04);
    wr(5'd13, 8'h01);
    wr(5'd0, 8'h5A);
    wr(5'd6, 8'h01);
    wait_idle();
    chk("R8 irq raised", {7'b0, irq}, 8'h01);
    rd_chk("R8 stat irq, R5 err cleared", 5'd8, 8'h02);
    wr(5'd8, 8'h02);
    chk("R9 irq lowered", {7'b0, irq}, 8'h00);
    rd_chk("R9 stat", 5'd8, 8'h00);
    wr(5'd13, 8'h00);
    wr(5'd0, 8'h5B);
    wr(5'd6, 8'h01);
    wait_idle();
    chk("R8 masked", {7'b0, irq}, 8'h00);
    wr(5'd7, 8'h00);
    wr(5'd13, 8'h01);
    wr(5'd0, 8'h5C);
    wr(5'd6, 8'h01);
    wait_idle();
    chk("R8 disabled", {7'b0, irq}, 8'h00);
    rd_chk("R8 stat no irq", 5'd8, 8'h00);
  endtask

  task automatic t_chain_halt(); // R6, R7
    int s0;
    clear_engine();
    s0 = stop_cnt;
    wr(5'd7, 8'h04);
    wr(5'd13, 8'h08);
    wr(5'd0, 8'h71);
    wr(5'd6, 8'h05);
    wait_idle();
    chk("R6 no stop when chained", 8'(stop_cnt - s0), 8'd0);
    rd_chk("R6 bus busy", 5'd9, 8'h50);
    wr(5'd0, 8'h72);
    wr(5'd6, 8'h05);
    wait_idle();
    chk("R6 no start when open", {7'b0, log_st[1]}, 8'h00);
    chk("R8 done irq masked", {7'b0, irq}, 8'h00);
    wr(5'd6, 8'h80);
    @(negedge clk);
    chk("R7 halt stop", 8'(stop_cnt - s0), 8'd1);
    chk("R7 halt irq", {7'b0, irq}, 8'h01);
    rd_chk("R7 bus free", 5'd9, 8'h40);
    rd_chk("R7 stat irq", 5'd8, 8'h02);
    wr(5'd8, 8'h02);
    wr(5'd7, 8'h00);
    wr(5'd13, 8'h00);
  endtask

  task automatic t_masks(); // R10, R11, R12
    wr(5'd7, 8'hFF);
    rd_chk("R10 mode mask, R11 flush not stored", 5'd7, 8'h3D);
    wr(5'd7, 8'h00);
    wr(5'd14, 8'hFF);
    rd_chk("R10 bytecnt mask", 5'd14, 8'h77);
    wr(5'd16, 8'hA5);
    rd_chk("R10 lines", 5'd16, 8'h05);
    wr(5'd12, 8'h33);
    rd_chk("R10 clkdiv", 5'd12, 8'h33);
    for (int i = 1; i <= 5; i++) wr(5'd0, 8'(i));
    rd_chk("R12 full", 5'd8, 8'h30);
    for (int i = 1; i <= 4; i++) rd_chk("R12 order", 5'd0, 8'(i));
    rd_chk("R12 fifth dropped", 5'd0, 8'hFF);
    wr(5'd0, 8'h09); wr(5'd0, 8'h0A);
    rd_chk("R11 before flush", 5'd8, 8'h20);
    wr(5'd7, 8'h40);
    rd_chk("R11 flushed", 5'd8, 8'h00);
    rd_chk("R11 empty data", 5'd0, 8'hFF);
  endtask

  task automatic t_maddr_stop(); // R14
    int s0;
    clear_engine();
    wr(5'd0, 8'h44);
    wr(5'd6, 8'h05);
    wait_idle();
    s0 = stop_cnt;
    rd_chk("R14 busy", 5'd9, 8'h50);
    wr(5'd4, 8'h52);
    @(negedge clk);
    chk("R14 stop", 8'(stop_cnt - s0), 8'd1);
    rd_chk("R14 free", 5'd9, 8'h40);
  endtask

  task automatic t_soft_reset(); // R13
    int s0;
    clear_engine();
    wr(5'd4, 8'hA4);
    wr(5'd5, 8'h3C);
    wr(5'd10, 8'h12);
    wr(5'd12, 8'h33);
    wr(5'd13, 8'h0F);
    wr(5'd16, 8'h03);
    wr(5'd0, 8'h66);
    wr(5'd6, 8'h05);
    wait_idle();
    wr(5'd7, 8'h04);
    wr(5'd0, 8'h67);
    s0 = stop_cnt;
    wr(5'd15, 8'h01);
    @(negedge clk);
    chk("R13 stop", 8'(stop_cnt - s0), 8'd1);
    rd_chk("R13 maddr lo kept", 5'd4, 8'hA4);
    rd_chk("R13 maddr hi kept", 5'd5, 8'h3C);
    rd_chk("R13 saddr kept", 5'd10, 8'h12);
    rd_chk("R13 clkdiv", 5'd12, 8'h00);
    rd_chk("R13 imask", 5'd13, 8'h00);
    rd_chk("R13 mode", 5'd7, 8'h00);
    rd_chk("R13 ctrl", 5'd6, 8'h00);
    rd_chk("R13 lines", 5'd16, 8'h0F);
    rd_chk("R13 xstat", 5'd9, 8'h40);
    rd_chk("R13 xctrl", 5'd15, 8'h00);
    rd_chk("R13 buffer", 5'd8, 8'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ctrl_readback();
    t_write_xfer();
    t_read_xfer();
    t_nack();
    t_irq();
    t_chain_halt();
    t_masks();
    t_maddr_stop();
    t_soft_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule